// File: doc/BRIEF.md
# Digital Delta-Sigma Bitstream Modulator

This block turns a signed multi-bit sample stream into a 1-bit stream whose density of ones follows the input level. It runs at the oversampled rate. On every cycle in which `en` is high it subtracts a full-scale feedback level from the input and adds the result into one or two cascaded integrators. It then takes the sign of the last integrator as the next output bit. The feedback level is picked by the bit decided on the previous enabled cycle, so the feedback loop holds one register of delay.

The loop order is a parameter with the value 1 or 2. Each integrator is two bits wider than the input and clamps at its signed limits instead of wrapping. A sticky flag records that clamping took place. The stream is meant to feed a decimation filter or a 1-bit output stage. The input is expected to stay within plus or minus full scale.

Top module: `dsm_modulator`

## Requirements
- R1: A synchronous reset clears every integrator, the output bit and the overflow flag to zero. After reset, `dout` = 0 and `ovf` = 0.
- R2: While `en` is low, the integrators, the output bit and the flag keep their values whatever `din` carries. When `en` returns high, the stream carries on as if the idle cycles had not occurred.
- R3: The feedback level is +FS when the stored bit is 1 and -FS when it is 0, with FS = 2^(DATA_W-1)-1. The stored bit is the one decided on the previous enabled cycle, so the first enabled cycle after reset feeds back -FS.
- R4: With ORDER = 1, each enabled cycle sets the integrator to its old value plus `din` minus the feedback level.
- R5: With ORDER = 2, the first integrator updates as in R4, and the second becomes its old value plus the new first-integrator value minus the same feedback level.
- R6: The new output bit is 1 when the updated last integrator is zero or greater, and 0 when it is negative. It appears on `dout` after the clock edge that ends the enabled cycle.
- R7: Each integrator is DATA_W+2 bits signed. A result above 2^(DATA_W+1)-1 or below -2^(DATA_W+1) is clamped to that limit.
- R8: `ovf` goes to 1 after the edge of any enabled cycle that clamps an integrator, and stays at 1 until reset.
- R9: For a constant in-range input x held over N enabled cycles, the number of ones is within a few counts of N*(x+FS)/(2*FS).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable at the oversampled rate |
| din | input | DATA_W | Signed input sample, two's complement |
| dout | output | 1 | Output bit stream |
| ovf | output | 1 | Sticky flag, set when an integrator clamps |

## Verification
A wrong integrator value cannot be seen directly. It shows up only as a changed output bit, either on the following edge or some cycles later, once the error is large enough to move the sign. For this reason the bench compares `dout` with a cycle-exact model on every cycle, rather than only checking the long-run density. An error in the feedback sign or in the one-cycle delay already changes the first few bits after reset. A wrap instead of a clamp shows up only after recovery, as a change in how many cycles the stream needs to come back from a pinned integrator. That recovery count is therefore checked directly.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  // Extra integrator bits above the input width.
  localparam int unsigned GUARD_BITS = 2;

  // Sign decision: non-negative maps to 1.
  function automatic logic sign_to_bit(input logic msb);
    return ~msb;
  endfunction
endpackage

// File: rtl/dsm_feedback.sv
module dsm_feedback #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     bit_d,
  output logic                     fb_bit,
  output logic signed [DATA_W-1:0] fb_val
);
  localparam logic signed [DATA_W-1:0] FS_POS = {1'b0, {(DATA_W-1){1'b1}}};

  function automatic logic signed [DATA_W-1:0] level_of(input logic b);
    logic signed [DATA_W-1:0] lv;
    lv = b ? FS_POS : -FS_POS;
    return lv;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)     fb_bit <= 1'b0;
    else if (en) fb_bit <= bit_d;
  end

  assign fb_val = level_of(fb_bit);

  // R3: the bit fed back is the one decided in the previous enabled cycle
  p_fb_delay_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> (fb_bit == $past(bit_d)));
  // R3: feedback magnitude is full scale with the sign of the stored bit
  p_fb_level_r3: assert property (@(posedge clk) disable iff (rst)
    fb_bit |-> (fb_val == FS_POS));
  // R2: stored bit held while idle
  p_fb_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(fb_bit));
endmodule

// File: rtl/dsm_integrator.sv
module dsm_integrator #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = DATA_W + 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [ACC_W-1:0]  acc_in,
  input  logic signed [DATA_W-1:0] fb_val,
  output logic signed [ACC_W-1:0]  acc_q,
  output logic signed [ACC_W-1:0]  acc_d,
  output logic                     sat_evt
);
  localparam int unsigned WIDE_W = ACC_W + 2;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  function automatic logic signed [WIDE_W-1:0] wide_sum(
    input logic signed [ACC_W-1:0]  a,
    input logic signed [ACC_W-1:0]  b,
    input logic signed [DATA_W-1:0] f
  );
    logic signed [WIDE_W-1:0] ea, eb, ef;
    ea = {{2{a[ACC_W-1]}}, a};
    eb = {{2{b[ACC_W-1]}}, b};
    ef = {{(WIDE_W-DATA_W){f[DATA_W-1]}}, f};
    return ea + eb - ef;
  endfunction

  function automatic logic out_of_range(input logic signed [WIDE_W-1:0] s);
    return !((s[WIDE_W-1:ACC_W-1] == '0) || (s[WIDE_W-1:ACC_W-1] == '1));
  endfunction

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [WIDE_W-1:0] s);
    logic signed [ACC_W-1:0] r;
    if (!out_of_range(s))    r = s[ACC_W-1:0];
    else if (s[WIDE_W-1])    r = ACC_MIN;
    else                     r = ACC_MAX;
    return r;
  endfunction

  logic signed [WIDE_W-1:0] raw;

  always_comb begin
    raw     = wide_sum(acc_q, acc_in, fb_val);
    sat_evt = out_of_range(raw);
    acc_d   = clamp(raw);
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  // R2: integrator holds while enable is low
  p_int_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));
  // R7: a clamping cycle lands exactly on a limit
  p_sat_limit_r7: assert property (@(posedge clk) disable iff (rst)
    (en && sat_evt) |=> (acc_q == ACC_MAX || acc_q == ACC_MIN));
  // R4: an unclamped enabled cycle stores the exact sum
  p_exact_sum_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !sat_evt) |=> (acc_q == $past(raw[ACC_W-1:0])));
endmodule

// File: rtl/dsm_quantizer.sv
module dsm_quantizer #(
  parameter int unsigned ACC_W = 18
) (
  input  logic signed [ACC_W-1:0] level,
  output logic                    bit_o
);
  import dsm_pkg::*;
  assign bit_o = sign_to_bit(level[ACC_W-1]);

  // R6: a negative level never produces a one
  always_comb begin
    if (level < 0) p_quant_neg_r6: assert (bit_o == 1'b0);
  end
endmodule

// File: rtl/dsm_modulator.sv
module dsm_modulator #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ORDER  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic signed [DATA_W-1:0] din,
  output logic                     dout,
  output logic                     ovf
);
  import dsm_pkg::*;

  localparam int unsigned ACC_W  = DATA_W + GUARD_BITS;
  localparam int unsigned STAGES = (ORDER >= 2) ? 2 : 1;

  logic signed [ACC_W-1:0]  st_in [STAGES];
  logic signed [ACC_W-1:0]  st_q  [STAGES];
  logic signed [ACC_W-1:0]  st_d  [STAGES];
  logic [STAGES-1:0]        st_sat;
  logic signed [DATA_W-1:0] fb_val;
  logic                     fb_bit;
  logic                     next_bit;

  assign st_in[0] = {{GUARD_BITS{din[DATA_W-1]}}, din};

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k > 0) begin : g_chain
      assign st_in[k] = st_d[k-1];
    end
    dsm_integrator #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_int (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .acc_in (st_in[k]),
      .fb_val (fb_val),
      .acc_q  (st_q[k]),
      .acc_d  (st_d[k]),
      .sat_evt(st_sat[k])
    );
    // R4/R5: each stage moves to its computed next value on enable
    p_stage_step_r5: assert property (@(posedge clk) disable iff (rst)
      en |=> (st_q[k] == $past(st_d[k])));
  end

  dsm_quantizer #(.ACC_W(ACC_W)) u_quant (
    .level(st_d[STAGES-1]),
    .bit_o(next_bit)
  );

  dsm_feedback #(.DATA_W(DATA_W)) u_fb (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .bit_d (next_bit),
    .fb_bit(fb_bit),
    .fb_val(fb_val)
  );

  assign dout = fb_bit;

  always_ff @(posedge clk) begin
    if (rst)                  ovf <= 1'b0;
    else if (en && |st_sat)   ovf <= 1'b1;
  end

  // R1: reset leaves the output bit and flag low
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!dout && !ovf));
  // R6: output bit agrees with the sign of the stored last integrator
  p_quant_r6: assert property (@(posedge clk) disable iff (rst)
    en |=> (dout == !st_q[STAGES-1][ACC_W-1]));
  // R8: a clamp raises the flag
  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    (en && |st_sat) |=> ovf);
  // R8: flag is sticky
  p_no_overflow_drop_r8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

// File: tb/dsm_modulator_tb.sv
module dsm_modulator_tb;
  localparam int DW = 8;
  localparam int FS = (1 << (DW-1)) - 1;
  localparam int HI = (1 << (DW+1)) - 1;
  localparam int LO = -(1 << (DW+1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic dout2, ovf2, dout1, ovf1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  int  m1_i, m2_i1, m2_i2;
  bit  m1_b, m2_b, m1_o, m2_o;

  always #2.5 clk = ~clk;

  dsm_modulator #(.DATA_W(DW), .ORDER(2)) u_dut (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout2), .ovf(ovf2));
  dsm_modulator #(.DATA_W(DW), .ORDER(1)) u_dut_o1 (
    .clk(clk), .rst(rst), .en(en), .din(din), .dout(dout1), .ovf(ovf1));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int limit(input int v, inout bit hit);
    if (v > HI) begin hit = 1'b1; return HI; end
    if (v < LO) begin hit = 1'b1; return LO; end
    return v;
  endfunction

  task automatic model_step(input int x);
    int f;
    bit h;
    // order one (R3, R4, R6, R7, R8)
    f = m1_b ? FS : -FS;
    h = 1'b0;
    m1_i = limit(m1_i + x - f, h);
    m1_b = (m1_i >= 0);
    if (h) m1_o = 1'b1;
    // order two (R5)
    f = m2_b ? FS : -FS;
    h = 1'b0;
    m2_i1 = limit(m2_i1 + x - f, h);
    m2_i2 = limit(m2_i2 + m2_i1 - f, h);
    m2_b = (m2_i2 >= 0);
    if (h) m2_o = 1'b1;
  endtask

  task automatic model_clear();
    m1_i = 0; m2_i1 = 0; m2_i2 = 0;
    m1_b = 0; m2_b = 0; m1_o = 0; m2_o = 0;
  endtask

  // one clock: drive at a falling edge, compare at the next falling edge
  task automatic tick(input bit e, input int x, input string req);
    en  = e;
    din = DW'(x);
    if (e) model_step(x);
    @(negedge clk);
    chk(req, "order1 dout", int'(dout1), int'(m1_b));
    chk(req, "order2 dout", int'(dout2), int'(m2_b));
    chk(req, "order1 ovf",  int'(ovf1),  int'(m1_o));
    chk(req, "order2 ovf",  int'(ovf2),  int'(m2_o));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b1;
    din = DW'(55);
    model_clear();
    @(negedge clk);
    @(negedge clk);
    chk("R1", "order1 dout after reset", int'(dout1), 0);
    chk("R1", "order2 dout after reset", int'(dout2), 0);
    chk("R1", "order1 ovf after reset",  int'(ovf1), 0);
    chk("R1", "order2 ovf after reset",  int'(ovf2), 0);
    rst = 1'b0;
    en  = 1'b0;
  endtask

  // R3 R4 R5 R6: zero input from reset gives 1,1,0,1 in both orders
  task automatic t_first_bits();
    int exp_bits [4] = '{1, 1, 0, 1};
    do_reset();
    for (int n = 0; n < 4; n++) begin
      tick(1'b1, 0, "R3");
      chk("R3", "order1 early bit", int'(dout1), exp_bits[n]);
      chk("R5", "order2 early bit", int'(dout2), exp_bits[n]);
    end
    for (int n = 0; n < 30; n++) tick(1'b1, (n * 37) % 200 - 100, "R4");
  endtask

  // R2: idle cycles with changing input leave everything untouched
  task automatic t_hold();
    bit b1, b2;
    do_reset();
    for (int n = 0; n < 7; n++) tick(1'b1, 30, "R2");
    b1 = dout1; b2 = dout2;
    for (int n = 0; n < 6; n++) begin
      tick(1'b0, -100 + 40 * n, "R2");
      chk("R2", "order1 dout idle", int'(dout1), int'(b1));
      chk("R2", "order2 dout idle", int'(dout2), int'(b2));
    end
    for (int n = 0; n < 20; n++) tick(1'b1, 30, "R2");
  endtask

  // R9: density of ones for a constant input
  task automatic t_density(input int x);
    int ones1 = 0, ones2 = 0, expn, n_tot;
    n_tot = 1000;
    do_reset();
    for (int n = 0; n < n_tot; n++) begin
      tick(1'b1, x, "R9");
      ones1 += dout1;
      ones2 += dout2;
    end
    expn = (n_tot * (x + FS) + FS) / (2 * FS);
    chk("R9", "order1 ones within 4", int'((ones1 - expn) <= 4 && (expn - ones1) <= 4), 1);
    chk("R9", "order2 ones within 8", int'((ones2 - expn) <= 8 && (expn - ones2) <= 8), 1);
  endtask

  // R7 R8: out-of-range input pins the integrators; recovery count shows clamping
  task automatic t_saturate();
    do_reset();
    for (int n = 0; n < 600; n++) tick(1'b1, -128, "R7");
    chk("R8", "order1 ovf set", int'(ovf1), 1);
    chk("R8", "order2 ovf set", int'(ovf2), 1);
    // order one sits at LO; +FS input with -FS feedback climbs 254 per cycle
    tick(1'b1, FS, "R7");
    chk("R7", "order1 recovery step1", int'(dout1), 0);
    tick(1'b1, FS, "R7");
    chk("R7", "order1 recovery step2", int'(dout1), 0);
    tick(1'b1, FS, "R7");
    chk("R7", "order1 recovery step3", int'(dout1), 1);
    for (int n = 0; n < 40; n++) tick(1'b1, 0, "R8");
    chk("R8", "order1 ovf sticky", int'(ovf1), 1);
    chk("R8", "order2 ovf sticky", int'(ovf2), 1);
    do_reset();
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();
    t_first_bits();
    t_hold();
    t_density(64);
    t_density(-90);
    t_saturate();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete got 0 expected 1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule